// File: doc/BRIEF.md
# Interrupt Coalescing Timer Unit

This block batches frame-completion events for one direction of a network MAC. It turns them into a single interrupt request. A design uses two copies, one on the transmit side and one on the receive side. Each copy has its own time threshold and frame-count threshold.

While coalescing is on, a frame counter tallies frame-done pulses. The interrupt is raised when the count reaches its threshold or when a countdown timer expires, whichever comes first. The timer holds still after an interrupt. It is reloaded with the time threshold and starts only when the next frame completes.

The timer counts in units of 64 ticks of a selectable source. The source is either the system clock (every `clk` cycle) or a synchronous interface-clock strobe. The request stays high until software pulses the acknowledge input. With coalescing off, every frame raises the request at once.

Top module: `irq_coalesce_unit`

## Requirements
- R1: After a synchronous reset, `irq_req` is 0.
- R2: With `coal_en` = 0, a `frame_done` pulse sampled at a clock edge makes `irq_req` 1 after that edge.
- R3: With `coal_en` = 1, the frame that brings the frame count up to `count_thresh` raises `irq_req` after the edge where it is sampled.
- R4: With no frame after an interrupt, the timer does not run, and `irq_req` stays 0 once acknowledged, however long the wait.
- R5: With `src_sel` = 1, `irq_req` rises exactly 64*`time_thresh` clock edges after the edge that samples the first frame following an interrupt, unless the frame count fires first.
- R6: With `src_sel` = 0, only edges where `if_tick` = 1 advance the timer, and expiry happens on the 64*`time_thresh`-th such edge after the starting frame.
- R7: A `time_thresh` of 0 behaves as 1, that is 64 source ticks.
- R8: `irq_req` holds 1 until an edge with `irq_ack` = 1. A new interrupt in the same cycle as the acknowledge wins, and the request stays 1.
- R9: Raising the interrupt clears the frame count and stops the timer. A frame sampled in the same cycle as a timer expiry is covered by that interrupt.
- R10: A `count_thresh` of 0 behaves as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| coal_en | input | 1 | 1 enables coalescing, 0 passes every frame through |
| src_sel | input | 1 | Tick source: 1 = system clock, 0 = `if_tick` strobe |
| if_tick | input | 1 | Interface-clock strobe, one cycle per interface tick |
| frame_done | input | 1 | One-cycle frame-completion pulse |
| time_thresh | input | 16 | Timer threshold in 64-tick units |
| count_thresh | input | 8 | Frame-count threshold |
| irq_ack | input | 1 | Acknowledge pulse that clears the request |
| irq_req | output | 1 | Coalesced interrupt request (registered) |

## Verification
Directed patterns separate the two ways an interrupt can fire. A burst of frames under a large time threshold isolates the count path. A lone frame under a large count threshold isolates the timer path, and its exact rise edge shows whether the 64-tick unit and the start-on-frame rule are right. A long idle wait with no frames tells a timer that starts on the frame apart from one that free-runs. A sparse interface strobe tells the selected source apart from the system clock. Random segments then mix frames, acknowledges, strobes, enable toggles and small thresholds against a cycle-level bench model, which exposes ordering faults such as acknowledge versus new interrupt and frames that coincide with expiry.

// File: rtl/irq_coal_pkg.sv
package irq_coal_pkg;
  localparam int UNIT_LOG2 = 6; // 64 source ticks per threshold unit

  function automatic logic [15:0] min_one16(input logic [15:0] v);
    return (v == '0) ? 16'd1 : v;
  endfunction
endpackage

// File: rtl/icu_prescaler.sv
module icu_prescaler #(
  parameter int LOG2 = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic start,
  input  logic src_en,
  output logic tick
);
  localparam logic [LOG2-1:0] LAST = {LOG2{1'b1}};
  logic [LOG2-1:0] pre;

  assign tick = run && src_en && (pre == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run || start) pre <= '0;
    else if (src_en)          pre <= pre + 1'b1;
  end

  assert_idle_clear_R4: assert property (@(posedge clk) disable iff (rst)
    !run |=> (pre == '0));
endmodule

// File: rtl/icu_countdown.sv
module icu_countdown #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          stop,
  input  logic          tick,
  input  logic [TW-1:0] load_val,
  output logic          run,
  output logic          expire
);
  logic [TW-1:0] rem;

  assign expire = run && tick && (rem == {{(TW-1){1'b0}}, 1'b1});

  always_ff @(posedge clk) begin
    if (rst) begin
      run <= 1'b0;
      rem <= '0;
    end else if (stop) begin
      run <= 1'b0;
    end else if (start) begin
      run <= 1'b1;
      rem <= (load_val == '0) ? {{(TW-1){1'b0}}, 1'b1} : load_val;
    end else if (run && tick) begin
      rem <= rem - 1'b1;
    end
  end

  assert_rem_nonzero_R5: assert property (@(posedge clk) disable iff (rst)
    run |-> (rem != '0));
  assert_stop_halts_R9: assert property (@(posedge clk) disable iff (rst)
    stop |=> !run);
endmodule

// File: rtl/icu_frame_count.sv
module icu_frame_count #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          frame,
  input  logic          clear,
  input  logic [CW-1:0] thresh,
  output logic          hit
);
  logic [CW-1:0] cnt;
  logic [CW:0]   eff;

  assign eff = (thresh == '0) ? {{CW{1'b0}}, 1'b1} : {1'b0, thresh};
  assign hit = en && frame && (({1'b0, cnt} + 1'b1) >= eff);

  always_ff @(posedge clk) begin
    if (rst || clear) cnt <= '0;
    else if (frame)   cnt <= cnt + 1'b1;
  end

  assert_hit_clears_R9: assert property (@(posedge clk) disable iff (rst)
    hit |=> (cnt == '0));
  assert_zero_thresh_R10: assert property (@(posedge clk) disable iff (rst)
    (en && frame && thresh == '0) |-> hit);
endmodule

// File: rtl/irq_coalesce_unit.sv
module irq_coalesce_unit #(
  parameter int TW = 16,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          coal_en,
  input  logic          src_sel,
  input  logic          if_tick,
  input  logic          frame_done,
  input  logic [TW-1:0] time_thresh,
  input  logic [CW-1:0] count_thresh,
  input  logic          irq_ack,
  output logic          irq_req
);
  import irq_coal_pkg::*;

  logic src_en, tick, run, expire, hit, fire, start, stop;

  assign src_en = src_sel ? 1'b1 : if_tick;
  assign fire   = coal_en ? (hit || expire) : frame_done;
  assign stop   = fire || !coal_en;
  assign start  = coal_en && frame_done && !fire && !run;

  icu_prescaler #(.LOG2(UNIT_LOG2)) u_pre (
    .clk(clk), .rst(rst), .run(run), .start(start), .src_en(src_en), .tick(tick)
  );

  icu_countdown #(.TW(TW)) u_tmr (
    .clk(clk), .rst(rst), .start(start), .stop(stop), .tick(tick),
    .load_val(time_thresh), .run(run), .expire(expire)
  );

  icu_frame_count #(.CW(CW)) u_cnt (
    .clk(clk), .rst(rst), .en(coal_en), .frame(frame_done), .clear(stop),
    .thresh(count_thresh), .hit(hit)
  );

  always_ff @(posedge clk) begin
    if (rst)          irq_req <= 1'b0;
    else if (fire)    irq_req <= 1'b1;
    else if (irq_ack) irq_req <= 1'b0;
  end

  assert_reset_low_R1: assert property (@(posedge clk)
    rst |=> !irq_req);
  assert_bypass_R2: assert property (@(posedge clk) disable iff (rst)
    (!coal_en && frame_done) |=> irq_req);
  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (irq_req && !irq_ack) |=> irq_req);
  assert_ack_clears_R8: assert property (@(posedge clk) disable iff (rst)
    (irq_ack && !fire) |=> !irq_req);
endmodule

// File: tb/irq_coalesce_unit_test.sv
module irq_coalesce_unit_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic coal_en = 1'b0, src_sel = 1'b1, if_tick = 1'b0, frame_done = 1'b0, irq_ack = 1'b0;
  logic [15:0] time_thresh = 16'd1;
  logic [7:0]  count_thresh = 8'd1;
  logic irq_req;

  int checks = 0, errors = 0;
  bit done = 0;

  // bench model state
  bit  m_irq, m_run;
  int  m_left, m_fc;

  always #2 clk = ~clk;

  irq_coalesce_unit uut (
    .clk(clk), .rst(rst), .coal_en(coal_en), .src_sel(src_sel), .if_tick(if_tick),
    .frame_done(frame_done), .time_thresh(time_thresh), .count_thresh(count_thresh),
    .irq_ack(irq_ack), .irq_req(irq_req)
  );

  function automatic int units(input logic [15:0] t);
    return (t == 0) ? 64 : 64 * int'(t);
  endfunction

  function automatic int cmax(input logic [7:0] c);
    return (c == 0) ? 1 : int'(c);
  endfunction

  task automatic model_step();
    bit fire, src;
    fire = 0;
    src  = src_sel ? 1'b1 : if_tick;
    if (rst) begin
      m_irq = 0; m_run = 0; m_fc = 0; m_left = 0;
      return;
    end
    if (!coal_en) begin
      fire = frame_done; m_run = 0; m_fc = 0;
    end else begin
      if (m_run && src && m_left == 1) fire = 1;
      if (frame_done && (m_fc + 1 >= cmax(count_thresh))) fire = 1;
      if (fire) begin
        m_run = 0; m_fc = 0;
      end else begin
        if (m_run && src) m_left--;
        if (frame_done) begin
          m_fc++;
          if (!m_run) begin m_run = 1; m_left = units(time_thresh); end
        end
      end
    end
    if (fire) m_irq = 1;
    else if (irq_ack) m_irq = 0;
  endtask

  task automatic check(input bit exp, input string req);
    checks++;
    if (irq_req !== exp) begin
      errors++;
      $display("FAIL %s: irq_req=%b expected %b at %0t", req, irq_req, exp, $time);
    end
  endtask

  // drive inputs for one edge, advance, and compare against the model
  task automatic cyc(input bit fd, input bit ack, input bit tk, input string req);
    frame_done = fd; irq_ack = ack; if_tick = tk;
    model_step();
    @(negedge clk);
    check(m_irq, req);
  endtask

  task automatic idle(input int n, input string req);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, req);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    process::self().srandom(32'd1234);
    @(negedge clk);
    rst = 1'b1; cyc(0, 0, 0, "R1"); cyc(0, 0, 0, "R1");
    rst = 1'b0;
    check(1'b0, "R1"); // reset state

    // R2: bypass
    coal_en = 0; cyc(1, 0, 0, "R2"); check(1'b1, "R2");
    cyc(0, 1, 0, "R8"); check(1'b0, "R8");
    // R8: ack and new interrupt together -> stays high
    cyc(1, 0, 0, "R2"); cyc(1, 1, 0, "R8"); check(1'b1, "R8");
    cyc(0, 1, 0, "R8"); check(1'b0, "R8");

    // R3 / R9: count path, count_thresh = 3
    coal_en = 1; src_sel = 1; time_thresh = 16'hFFFF; count_thresh = 8'd3;
    cyc(1, 0, 0, "R3"); cyc(1, 0, 0, "R3"); check(1'b0, "R3");
    cyc(1, 0, 0, "R3"); check(1'b1, "R3");
    cyc(0, 1, 0, "R9");
    cyc(1, 0, 0, "R9"); cyc(1, 0, 0, "R9"); check(1'b0, "R9");
    cyc(1, 0, 0, "R9"); check(1'b1, "R9");
    cyc(0, 1, 0, "R8");

    // R4: no frame, timer idle for a long time
    idle(400, "R4"); check(1'b0, "R4");

    // R5: system clock, time_thresh = 2 -> 128 edges
    count_thresh = 8'd200; time_thresh = 16'd2;
    cyc(1, 0, 0, "R5");
    idle(127, "R5"); check(1'b0, "R5");
    cyc(0, 0, 0, "R5"); check(1'b1, "R5");
    cyc(0, 1, 0, "R8");

    // R7: time_thresh 0 acts as 1 -> 64 edges
    time_thresh = 16'd0;
    cyc(1, 0, 0, "R7");
    idle(63, "R7"); check(1'b0, "R7");
    cyc(0, 0, 0, "R7"); check(1'b1, "R7");
    cyc(0, 1, 0, "R8");

    // R6: interface strobe every 3rd cycle, time_thresh 1 -> 64 strobes
    src_sel = 0; time_thresh = 16'd1;
    cyc(1, 0, 1, "R6");
    for (int k = 0; k < 63; k++) begin
      cyc(0, 0, 0, "R6"); cyc(0, 0, 0, "R6"); cyc(0, 0, 1, "R6");
    end
    check(1'b0, "R6");
    cyc(0, 0, 0, "R6"); cyc(0, 0, 0, "R6"); check(1'b0, "R6");
    cyc(0, 0, 1, "R6"); check(1'b1, "R6");
    cyc(0, 1, 0, "R8");

    // R10: count_thresh 0 acts as 1
    src_sel = 1; count_thresh = 8'd0; time_thresh = 16'hFFFF;
    cyc(1, 0, 0, "R10"); check(1'b1, "R10");
    cyc(0, 1, 0, "R8"); check(1'b0, "R8");

    // random segments against the model
    for (int s = 0; s < 40; s++) begin
      src_sel      = $urandom_range(0, 1);
      coal_en      = ($urandom_range(0, 9) != 0);
      time_thresh  = 16'($urandom_range(0, 3));
      count_thresh = 8'($urandom_range(0, 7));
      for (int i = 0; i < 400; i++)
        cyc($urandom_range(0, 39) == 0, $urandom_range(0, 49) == 0,
            $urandom_range(0, 1), "R9");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule